// File: doc/BRIEF.md
# Gaussian Parameter Stream Compressor

This block is a streaming lossless encoder for the per-pixel parameters of a multi-component Gaussian background model. Each component has its own encoding lane, and every lane accepts one parameter per clock. For each incoming value the lane forms a prediction error and maps it to a non-negative code number. It then builds an Exp-Golomb codeword from that number without any logarithm, and appends the codeword to a running bit stream that is cut into 32-bit words for a memory bus.

A pixel is presented as a sequence of beats. Each beat carries one parameter kind (mean, variance or weight) for all components at once. Weights are predicted from the same lane's value at the left neighbour pixel. Means and variances are predicted the same way in the first lane, and in every other lane from the preceding lane's value at the same pixel. A line-start flag zeroes every prediction for the beats of a line's first pixel. A flush beat closes a lane's stream by padding the last partial word with zeros.

The three pipeline sections are prediction, encoding and packing, with a balancing delay between encoder and packer. A parameter therefore appears in the output words a fixed number of cycles after it is accepted. Packing uses a wide shift window and no local memory. Up to two words per lane can be produced in one clock, which lets the lane keep up with the longest codewords at full rate.

Top module: `gauss_param_encoder`

## Requirements
- R1: Lane 0 predicts every kind from its own value of the same kind at the previous accepted beat of that kind; the kind input uses 0 for mean, 1 for variance, and 2 or 3 for weight.
- R2: In lanes above 0, a mean or variance beat is predicted from the value of lane l-1 in the same beat.
- R3: A weight beat in every lane is predicted from that lane's previous weight, and input bits at and above position 16 of a weight value are ignored (treated as zero).
- R4: A beat with the line-start flag high uses a prediction of zero in every lane for every kind.
- R5: The prediction error d is one bit wider than the value; d greater than 0 maps to code number 2d-1, and d of 0 or less maps to -2d.
- R6: With v equal to the code number plus 1 and m the index of the highest set bit of v, the codeword is m zero bits followed by the m+1 bits of v (most significant first), giving 2m+1 bits.
- R7: Codewords are concatenated most significant bit first and cut into 32-bit words. Lane l places its words at out_words[l*64 +: 64] with the earlier word in the upper 32 bits, and puts the number of new words (0, 1 or 2) at out_count[2l +: 2]. Unused word positions are zero.
- R8: A beat accepted at a rising edge contributes its words at the outputs right after the ninth following rising edge.
- R9: A flush with in_valid low emits the pending bits of each lane as one word padded with zeros. A lane with no pending bits emits nothing.
- R10: During and right after reset, all counts are zero, no bits are pending, and every stored prediction is zero.
- R11: Beats are accepted on consecutive clocks with no stall, including beats whose codewords are 49 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A parameter beat is present |
| in_line_start | input | 1 | Beat belongs to the first pixel of a line |
| in_flush | input | 1 | Close the streams (honoured when in_valid is low) |
| in_kind | input | 2 | 0 mean, 1 variance, 2 or 3 weight |
| in_values | input | 72 | Lane l value at bits [l*24 +: 24] |
| out_words | output | 192 | Up to two 32-bit words per lane |
| out_count | output | 6 | Number of valid words per lane |

## Verification
A behavioural model keeps one bit queue per lane and predicts the words and counts expected at every clock. The first pattern is interleaved mean, variance and weight beats over short lines. It separates intra from inter prediction and shows whether the line-start reset of all predictions is honoured. Small signed steps of both polarities distinguish the positive and non-positive code-number mappings. Alternating full-scale values force 49-bit codewords and double-word clocks. Weights with noise in the upper bits expose a missing mask. Flushes with pending and with empty fills, plus a hand-worked single codeword, pin down the padding, the bit order and the exact latency.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [1:0] {
    PK_MEAN  = 2'd0,
    PK_VAR   = 2'd1,
    PK_WGT   = 2'd2,
    PK_WGT_B = 2'd3
  } param_kind_e;

  typedef struct packed {
    logic flush;
    logic data;
  } beat_tag_t;

  function automatic logic kind_is_weight(input param_kind_e k);
    return (k == PK_WGT) || (k == PK_WGT_B);
  endfunction

  function automatic logic [1:0] kind_slot(input param_kind_e k);
    return kind_is_weight(k) ? 2'd2 : logic'(k == PK_VAR) ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/gpe_predictor.sv
module gpe_predictor
  import gpe_pkg::*;
#(
  parameter int NCOMP  = 3,
  parameter int PW     = 24,
  parameter int MEAN_W = 24,
  parameter int VAR_W  = 24,
  parameter int WGT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_line_start,
  input  logic                  in_flush,
  input  logic [1:0]            in_kind,
  input  logic [NCOMP*PW-1:0]   in_values,
  output beat_tag_t             err_tag,
  output logic [NCOMP*(PW+1)-1:0] err_flat
);

  localparam int EW = PW + 1;

  function automatic logic [PW-1:0] kind_mask(input param_kind_e k);
    logic [PW-1:0] m;
    m = '0;
    for (int b = 0; b < PW; b++) begin
      if (kind_is_weight(k))  m[b] = (b < WGT_W);
      else if (k == PK_VAR)   m[b] = (b < VAR_W);
      else                    m[b] = (b < MEAN_W);
    end
    return m;
  endfunction

  function automatic logic [EW-1:0] pred_error(input logic [PW-1:0] value,
                                               input logic [PW-1:0] pred);
    return {1'b0, value} - {1'b0, pred};
  endfunction

  param_kind_e     kind;
  logic            is_wgt;
  logic [1:0]      kidx;
  logic [PW-1:0]   mask;
  logic [PW-1:0]   cur [NCOMP];

  assign kind   = param_kind_e'(in_kind);
  assign is_wgt = kind_is_weight(kind);
  assign kidx   = kind_slot(kind);
  assign mask   = kind_mask(kind);

  always_comb begin
    for (int l = 0; l < NCOMP; l++) cur[l] = in_values[l*PW +: PW] & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_tag <= '0;
    else        err_tag <= '{flush: in_flush & ~in_valid, data: in_valid};
  end

  for (genvar l = 0; l < NCOMP; l++) begin : g_lane
    logic [PW-1:0] left_q [3];
    logic [PW-1:0] inter_src;
    logic [PW-1:0] pred;
    logic [EW-1:0] err_q;
    logic          use_intra;

    if (l == 0) begin : g_first
      assign inter_src = '0;
      assign use_intra = 1'b1;
    end else begin : g_rest
      assign inter_src = cur[l-1];
      assign use_intra = is_wgt;
    end

    always_comb begin
      if (in_line_start)  pred = '0;
      else if (use_intra) pred = left_q[kidx];
      else                pred = inter_src;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < 3; k++) left_q[k] <= '0;
        err_q <= '0;
      end else begin
        err_q <= pred_error(cur[l], pred);
        if (in_valid) left_q[kidx] <= cur[l];
      end
    end

    assign err_flat[l*EW +: EW] = err_q;

    // R4: a line-start beat leaves the raw value as the error
    assert_line_start_zero_pred_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_line_start) |=> (err_q == {1'b0, $past(cur[l])}));
  end

endmodule

// File: rtl/gpe_eg_encoder.sv
module gpe_eg_encoder
  import gpe_pkg::*;
#(
  parameter int PW  = 24,
  parameter int CWW = 2*PW + 1,
  parameter int LW  = $clog2(2*PW + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  beat_tag_t       in_tag,
  input  logic [PW:0]     in_err,
  output beat_tag_t       cw_tag,
  output logic [CWW-1:0]  cw_code,
  output logic [LW-1:0]   cw_len
);

  localparam int EW  = PW + 1;
  localparam int CNW = PW + 2;
  localparam int MW  = $clog2(CNW);

  function automatic logic [CNW-1:0] to_code_number(input logic [EW-1:0] err);
    logic [CNW-1:0] twice;
    twice = {err[EW-1], err} << 1;
    if (!err[EW-1] && (err != '0)) return twice - CNW'(1);
    else                           return CNW'(0) - twice;
  endfunction

  function automatic logic [MW-1:0] msb_index(input logic [CNW-1:0] v);
    logic [MW-1:0] idx;
    idx = '0;
    for (int b = 0; b < CNW; b++) if (v[b]) idx = MW'(b);
    return idx;
  endfunction

  beat_tag_t      tag_a;
  logic [CNW-1:0] cn_q;
  logic [CNW-1:0] cnp1;
  logic [MW-1:0]  lead;

  assign cnp1 = cn_q + CNW'(1);
  assign lead = msb_index(cnp1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_a   <= '0;
      cn_q    <= '0;
      cw_tag  <= '0;
      cw_code <= '0;
      cw_len  <= '0;
    end else begin
      tag_a   <= in_tag;
      cn_q    <= to_code_number(in_err);
      cw_tag  <= tag_a;
      cw_code <= CWW'(cnp1);
      cw_len  <= LW'(2 * int'(lead) + 1);
    end
  end

  // R6: codeword length is always odd
  assert_cw_len_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cw_tag.data |-> cw_len[0]);

  // R6: the marker one sits exactly after the leading zeros
  assert_cw_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cw_tag.data |-> ((cw_code >> (cw_len >> 1)) == CWW'(1)));

endmodule

// File: rtl/gpe_delay.sv
module gpe_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_pipe
    logic [W-1:0] stage_q [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
        stage_q[0] <= d;
        for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
    end
    assign q = stage_q[DEPTH-1];
  end

endmodule

// File: rtl/gpe_packer.sv
module gpe_packer
  import gpe_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CWW   = 49,
  parameter int LW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  beat_tag_t          in_tag,
  input  logic [CWW-1:0]     in_code,
  input  logic [LW-1:0]      in_len,
  output logic [2*BUS_W-1:0] out_words,
  output logic [1:0]         out_count
);

  localparam int WIN = 3 * BUS_W;
  localparam int FW  = $clog2(BUS_W);

  logic [BUS_W-1:0]   acc_q, acc_d;
  logic [FW-1:0]      fill_q, fill_d;
  logic [WIN-1:0]     win;
  logic [2*BUS_W-1:0] words_d;
  logic [1:0]         count_d;
  int                 total;
  int                 sh;

  always_comb begin
    total   = int'(fill_q) + int'(in_len);
    sh      = WIN - total;
    win     = {acc_q, {(2*BUS_W){1'b0}}} | (WIN'(in_code) << sh);
    acc_d   = acc_q;
    fill_d  = fill_q;
    words_d = '0;
    count_d = 2'd0;
    if (in_tag.data) begin
      if (total >= 2*BUS_W) begin
        words_d = win[WIN-1 -: 2*BUS_W];
        count_d = 2'd2;
        acc_d   = win[BUS_W-1:0];
        fill_d  = FW'(total - 2*BUS_W);
      end else if (total >= BUS_W) begin
        words_d = {win[WIN-1 -: BUS_W], {BUS_W{1'b0}}};
        count_d = 2'd1;
        acc_d   = win[2*BUS_W-1 -: BUS_W];
        fill_d  = FW'(total - BUS_W);
      end else begin
        acc_d   = win[WIN-1 -: BUS_W];
        fill_d  = FW'(total);
      end
    end else if (in_tag.flush && (fill_q != '0)) begin
      words_d = {acc_q, {BUS_W{1'b0}}};
      count_d = 2'd1;
      acc_d   = '0;
      fill_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      fill_q    <= '0;
      out_words <= '0;
      out_count <= '0;
    end else begin
      acc_q     <= acc_d;
      fill_q    <= fill_d;
      out_words <= words_d;
      out_count <= count_d;
    end
  end

  // R7: codeword lengths arriving from the encoder are in range
  assert_code_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_tag.data |-> ((in_len != '0) && (int'(in_len) <= CWW)));

  // R7: idle clocks neither emit words nor move the fill
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_tag.data && !in_tag.flush) |=> ((out_count == 2'd0) && (fill_q == $past(fill_q))));

  // R9: a flush leaves no pending bits
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tag.flush && !in_tag.data) |=> (fill_q == '0));

  // R9: a flush with pending bits emits exactly one word
  assert_flush_emits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tag.flush && !in_tag.data && (fill_q != '0)) |=> (out_count == 2'd1));

endmodule

// File: rtl/gauss_param_encoder.sv
module gauss_param_encoder
  import gpe_pkg::*;
#(
  parameter int NCOMP   = 3,
  parameter int MEAN_W  = 24,
  parameter int VAR_W   = 24,
  parameter int WGT_W   = 16,
  parameter int BUS_W   = 32,
  parameter int LATENCY = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_line_start,
  input  logic                       in_flush,
  input  logic [1:0]                 in_kind,
  input  logic [NCOMP*((MEAN_W > VAR_W ? (MEAN_W > WGT_W ? MEAN_W : WGT_W) : (VAR_W > WGT_W ? VAR_W : WGT_W)))-1:0] in_values,
  output logic [NCOMP*2*BUS_W-1:0]   out_words,
  output logic [NCOMP*2-1:0]         out_count
);

  localparam int PW    = (MEAN_W > VAR_W) ? ((MEAN_W > WGT_W) ? MEAN_W : WGT_W)
                                          : ((VAR_W > WGT_W) ? VAR_W : WGT_W);
  localparam int EW    = PW + 1;
  localparam int CWW   = 2*PW + 1;
  localparam int LW    = $clog2(CWW + 1);
  localparam int DLY   = (LATENCY > 3) ? LATENCY - 3 : 0;
  localparam int DW    = 2 + CWW + LW;

  beat_tag_t             err_tag;
  logic [NCOMP*EW-1:0]   err_flat;

  gpe_predictor #(
    .NCOMP(NCOMP), .PW(PW), .MEAN_W(MEAN_W), .VAR_W(VAR_W), .WGT_W(WGT_W)
  ) u_pred (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_line_start(in_line_start), .in_flush(in_flush),
    .in_kind(in_kind), .in_values(in_values),
    .err_tag(err_tag), .err_flat(err_flat)
  );

  for (genvar l = 0; l < NCOMP; l++) begin : g_lane
    beat_tag_t          cw_tag, pk_tag;
    logic [CWW-1:0]     cw_code, pk_code;
    logic [LW-1:0]      cw_len, pk_len;
    logic [DW-1:0]      dly_q;

    gpe_eg_encoder #(.PW(PW), .CWW(CWW), .LW(LW)) u_enc (
      .clk(clk), .rst_n(rst_n),
      .in_tag(err_tag), .in_err(err_flat[l*EW +: EW]),
      .cw_tag(cw_tag), .cw_code(cw_code), .cw_len(cw_len)
    );

    gpe_delay #(.W(DW), .DEPTH(DLY)) u_dly (
      .clk(clk), .rst_n(rst_n),
      .d({cw_tag, cw_code, cw_len}), .q(dly_q)
    );

    assign {pk_tag, pk_code, pk_len} = dly_q;

    gpe_packer #(.BUS_W(BUS_W), .CWW(CWW), .LW(LW)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .in_tag(pk_tag), .in_code(pk_code), .in_len(pk_len),
      .out_words(out_words[l*2*BUS_W +: 2*BUS_W]),
      .out_count(out_count[l*2 +: 2])
    );
  end

endmodule

// File: tb/gauss_param_encoder_test.sv
`timescale 1ns/1ps
module gauss_param_encoder_test;

  localparam int NC  = 3;
  localparam int PW  = 24;
  localparam int BW  = 32;
  localparam int LAT = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, in_line_start = 1'b0, in_flush = 1'b0;
  logic [1:0]        in_kind = 2'd0;
  logic [NC*PW-1:0]  in_values = '0;
  logic [NC*2*BW-1:0] out_words;
  logic [NC*2-1:0]   out_count;

  gauss_param_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
    .in_flush(in_flush), .in_kind(in_kind), .in_values(in_values),
    .out_words(out_words), .out_count(out_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0, errors = 0;
  string tag = "R10";
  bit    done = 1'b0;

  logic [63:0]   exp_w [NC][16];
  int            exp_n [NC][16];
  bit            bq [NC][$];
  logic [PW-1:0] left_m [NC][3];

  initial begin
    for (int l = 0; l < NC; l++) begin
      for (int s = 0; s < 16; s++) begin exp_w[l][s] = '0; exp_n[l][s] = 0; end
      for (int k = 0; k < 3; k++) left_m[l][k] = '0;
    end
  end

  task automatic pop_word(int l, int slot);
    logic [31:0] w;
    for (int b = 31; b >= 0; b--) w[b] = bq[l].pop_front();
    if (exp_n[l][slot] == 0) exp_w[l][slot] = {w, 32'h0};
    else                     exp_w[l][slot][31:0] = w;
    exp_n[l][slot]++;
  endtask

  task automatic model_beat(int kind, bit ls, logic [PW-1:0] v [NC], int slot);
    logic [PW-1:0] cur [NC];
    int widx;
    widx = (kind >= 2) ? 2 : kind;
    for (int l = 0; l < NC; l++) cur[l] = (kind >= 2) ? (v[l] & 24'h00FFFF) : v[l];
    for (int l = 0; l < NC; l++) begin
      longint p, d, cn, val;
      int m;
      if (ls) p = 0;
      else if (l == 0 || kind >= 2) p = longint'(left_m[l][widx]);
      else p = longint'(cur[l-1]);
      d   = longint'(cur[l]) - p;
      cn  = (d > 0) ? 2*d - 1 : -2*d;
      val = cn + 1;
      m = 0;
      while ((val >> (m + 1)) != 0) m++;
      repeat (m) bq[l].push_back(1'b0);
      for (int b = m; b >= 0; b--) bq[l].push_back(val[b]);
      while (bq[l].size() >= 32) pop_word(l, slot);
    end
    for (int l = 0; l < NC; l++) left_m[l][widx] = cur[l];
  endtask

  task automatic model_flush(int slot);
    for (int l = 0; l < NC; l++) begin
      if (bq[l].size() > 0) begin
        while (bq[l].size() < 32) bq[l].push_back(1'b0);
        pop_word(l, slot);
      end
    end
  endtask

  task automatic check_outputs();
    int s;
    s = cyc % 16;
    for (int l = 0; l < NC; l++) begin
      logic [63:0] aw;
      int an;
      aw = out_words[l*64 +: 64];
      an = int'(out_count[l*2 +: 2]);
      checks++;
      if (an != exp_n[l][s] || aw != exp_w[l][s]) begin
        errors++;
        $display("FAIL %s lane %0d cycle %0d: actual count=%0d words=%h expected count=%0d words=%h",
                 tag, l, cyc, an, aw, exp_n[l][s], exp_w[l][s]);
      end
      exp_n[l][s] = 0;
      exp_w[l][s] = '0;
    end
  endtask

  task automatic drive(bit vld, bit fl, int kind, bit ls,
                       logic [PW-1:0] v0, logic [PW-1:0] v1, logic [PW-1:0] v2);
    logic [PW-1:0] v [NC];
    int slot;
    @(negedge clk);
    check_outputs();
    v = '{v0, v1, v2};
    in_valid = vld; in_flush = fl; in_kind = kind[1:0]; in_line_start = ls;
    in_values = {v2, v1, v0};
    slot = (cyc + LAT + 1) % 16;
    if (rst_n) begin
      if (vld)     model_beat(kind, ls, v, slot);
      else if (fl) model_flush(slot);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pixel(bit ls, logic [PW-1:0] m0, logic [PW-1:0] m1, logic [PW-1:0] m2,
                       logic [PW-1:0] s0, logic [PW-1:0] s1, logic [PW-1:0] s2,
                       logic [PW-1:0] w0, logic [PW-1:0] w1, logic [PW-1:0] w2);
    drive(1, 0, 0, ls, m0, m1, m2);
    drive(1, 0, 1, ls, s0, s1, s2);
    drive(1, 0, 2, ls, w0, w1, w2);
  endtask

  initial begin
    // R10: reset state
    tag = "R10";
    idle(4);
    @(negedge clk);
    checks++;
    if (out_count != '0) begin
      errors++;
      $display("FAIL R10 reset: actual count=%h expected count=0", out_count);
    end
    rst_n = 1'b1;
    drive(1, 0, 0, 0, 24'd5, 24'd9, 24'd1);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R6 and R8: one hand-worked codeword, error 2 gives bits 00100
    tag = "R6";
    drive(1, 0, 0, 1, 24'd2, 24'd2, 24'd2);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(9);
    @(negedge clk);
    checks++;
    if (out_count[1:0] != 2'd1 || out_words[63:32] != 32'h2000_0000) begin
      errors++;
      $display("FAIL R6 R8 codeword: actual count=%0d word=%h expected count=1 word=20000000",
               out_count[1:0], out_words[63:32]);
    end
    check_outputs();
    idle(4);

    // R1 R2 R3 R4: interleaved pixels over two short lines
    tag = "R1 R2 R4";
    for (int line = 0; line < 2; line++) begin
      for (int px = 0; px < 5; px++) begin
        pixel(px == 0,
              24'(1000 + 7*px + line), 24'(1003 + 5*px), 24'(990 - 3*px),
              24'(50 + px), 24'(48 + 2*px), 24'(61 - px),
              24'(300 + px), 24'(280 - px), 24'(310 + 2*px));
      end
    end
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R5: small errors of both signs
    tag = "R5";
    drive(1, 0, 0, 1, 24'd100, 24'd100, 24'd100);
    drive(1, 0, 0, 0, 24'd101, 24'd100, 24'd102);
    drive(1, 0, 0, 0, 24'd99, 24'd101, 24'd97);
    drive(1, 0, 0, 0, 24'd99, 24'd99, 24'd99);
    drive(1, 0, 0, 0, 24'd96, 24'd104, 24'd95);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R7 R11: full-scale swings, 49-bit codes back to back
    tag = "R7 R11";
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, i % 2, (i == 0),
            (i % 2) ? 24'hFFFFFF : 24'h0, (i % 2) ? 24'h0 : 24'hFFFFFF, 24'h800001);
    end
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R3: weights with noise above bit 15, kind 3 as weight
    tag = "R3";
    drive(1, 0, 2, 1, 24'hAB1234, 24'h001234, 24'hFF0000);
    drive(1, 0, 3, 0, 24'h5A1236, 24'hC31230, 24'h0F0002);
    drive(1, 0, 2, 0, 24'h771234, 24'h011234, 24'hF00001);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R9: flush with nothing pending emits nothing, twice in a row
    tag = "R9";
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 24'd3, 24'd3, 24'd3);
    drive(0, 1, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle(12);

    // R8 R11: long random stream with walking values
    tag = "R8 R11";
    begin
      logic [PW-1:0] base [NC];
      for (int l = 0; l < NC; l++) base[l] = 24'(l * 4000 + 12345);
      for (int i = 0; i < 600; i++) begin
        int k;
        k = int'($urandom_range(0, 3));
        for (int l = 0; l < NC; l++) begin
          if ($urandom_range(0, 15) == 0) base[l] = 24'($urandom);
          else base[l] = base[l] + 24'($urandom_range(0, 8)) - 24'd4;
        end
        if ($urandom_range(0, 9) == 0) idle(1);
        drive(1, 0, k, ($urandom_range(0, 24) == 0), base[0], base[1] ^ 24'($urandom_range(0, 3)), base[2]);
      end
      drive(0, 1, 0, 0, 0, 0, 0);
      idle(14);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule